// File: doc/BRIEF.md
# Two-Wire Register Access Slave

This block lets an external two-wire bus master read and write a bank of 8-bit registers that sits next to it. The bus clock and data pins are sampled by a much faster system clock, and every flop in the block runs on that system clock. The block never drives the bus clock. It drives data only through an open-drain enable: when `sda_oe` is high the pad pulls data low, and when it is low the pad releases the line.

A write is one bus transaction: a start, the device address with direction bit 0, one register pointer byte, and one data byte. The slave acknowledges each of these bytes. It then pulses the register-bank write strobe. A read first loads the pointer in the same way. The master then sends a repeated start and the device address with direction bit 1, and the slave shifts out the addressed register. The device address is one of two fixed 7-bit codes. A strap input picks the code, and the strap is captured once after reset.

The controller is a single state machine with these states:
- `ST_IDLE`: waits for a start.
- `ST_DEV`: receives the address byte.
- `ST_DEV_ACK`: acknowledges the address byte.
- `ST_PTR`: receives the pointer byte.
- `ST_PTR_ACK`: acknowledges the pointer byte.
- `ST_WDAT`: receives the write-data byte.
- `ST_WDAT_ACK`: acknowledges the write-data byte.
- `ST_TX`: shifts the read byte out.
- `ST_TX_ACK`: lets the master drive its acknowledge bit.

These transitions apply in every state:
- A start moves to `ST_DEV`.
- A stop moves to `ST_IDLE`.

All other transitions happen on a falling bus-clock edge:
- `ST_DEV` to `ST_DEV_ACK` when the address matches, or to `ST_IDLE` when it does not.
- `ST_DEV_ACK` to `ST_PTR` when the direction bit is 0, or to `ST_TX` when it is 1.
- `ST_PTR` to `ST_PTR_ACK`, then `ST_PTR_ACK` to `ST_WDAT`.
- `ST_WDAT` to `ST_WDAT_ACK`, then `ST_WDAT_ACK` to `ST_IDLE`.
- `ST_TX` to `ST_TX_ACK`, then `ST_TX_ACK` to `ST_IDLE`.

Top module: `twi_reg_slave`

## Requirements
- R1: After reset, `sda_oe` and `reg_we` are low and the slave is idle.
- R2: A start (data falls while clock is high) always begins a new address byte, even in the middle of a byte. A stop (data rises while clock is high) returns the slave to idle and releases data.
- R3: The first byte after a start carries the device address MSB first in bits 7:1, and its bit 0 is the direction (1 = read). The address is 0x55 when `addr_sel` is low at reset and 0x33 when it is high. Changes of `addr_sel` after reset have no effect.
- R4: On an address mismatch, the slave drives no acknowledge and ignores all bus activity until the next start.
- R5: While the master sends a byte, the slave keeps data released. It acknowledges an accepted address, pointer or write-data byte by holding `sda_oe` high through the high phase of the ninth clock. `sda_oe` only rises while the bus clock is low.
- R6: After the data byte's acknowledge ends, `reg_we` pulses for exactly one cycle. During that pulse, `reg_addr` equals the pointer byte and `reg_wdata` equals the data byte.
- R7: A byte sent after the acknowledged data byte is not acknowledged and causes no write.
- R8: After a repeated start and the read address, the slave shifts out `reg_rdata` at the retained pointer, MSB first. Each bit is driven as `sda_oe` equal to the inverse of the bit.
- R9: After the eight read bits, the slave releases data for the master's acknowledge bit. Whatever the master answers, the slave drives nothing more until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_sel | input | 1 | Device address strap, captured after reset |
| scl_i | input | 1 | Bus clock pin |
| sda_i | input | 1 | Bus data pin (resolved line level) |
| sda_oe | output | 1 | Pull data low when high |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_addr | output | DATA_W | Register pointer |
| reg_wdata | output | DATA_W | Register write data |
| reg_rdata | input | DATA_W | Register read data at `reg_addr` |

## Verification
The bench targets these corner cases:
- **Start in the middle of a byte.** A design that fails to clear its bit counter would misalign the following address and fail to acknowledge it.
- **Stop in the middle of a byte.** Same failure mode as the start case.
- **Extra byte after a completed write.** A design that loops back to data reception would acknowledge the byte and issue a second write.
- **Read bytes with MSB 0 and MSB 1, followed by both master acknowledge and master no-acknowledge.** A design with a shift off by one, or one that keeps driving after the eighth bit, corrupts the byte or pulls the line low during a second read.
- **Strap moved without reset, then moved with reset.** This shows whether the address code is latched or follows the pin live.

// File: rtl/twi_pkg.sv
package twi_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_TX,
        ST_TX_ACK
    } twi_state_e;

endpackage

// File: rtl/twi_pin_sync.sv
module twi_pin_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], din[g]};
        end
        assign dout[g] = chain[STAGES-1];
    end

endmodule

// File: rtl/twi_cond_detect.sv
module twi_cond_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic start,
    output logic stop,
    output logic scl_rise,
    output logic scl_fall
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign start    = scl_q & scl_s & sda_q & ~sda_s;
    assign stop     = scl_q & scl_s & ~sda_q & sda_s;
    assign scl_rise = ~scl_q & scl_s;
    assign scl_fall = scl_q & ~scl_s;

endmodule

// File: rtl/twi_reg_slave.sv
module twi_reg_slave
    import twi_pkg::*;
#(
    parameter int          DATA_W      = 8,
    parameter int          SYNC_STAGES = 2,
    parameter logic [6:0]  DEV_CODE_LO = 7'h55,
    parameter logic [6:0]  DEV_CODE_HI = 7'h33
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_sel,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic              reg_we,
    output logic [DATA_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] reg_rdata
);

    localparam int DEV_W = DATA_W - 1;
    localparam int CNT_W = $clog2(DATA_W + 1);

    logic             scl_s, sda_s;
    logic             start, stop, scl_rise, scl_fall;
    twi_state_e       state_q, state_d;
    logic [CNT_W-1:0] bitcnt;
    logic [DATA_W-1:0] shreg, ptr_q;
    logic             rw_q, sel_q, cap_q;
    logic             byte_full, addr_hit;
    logic [DEV_W-1:0] dev_code;

    twi_pin_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({scl_i, sda_i}),
        .dout ({scl_s, sda_s})
    );

    twi_cond_detect u_cond (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_s   (scl_s),
        .sda_s   (sda_s),
        .start   (start),
        .stop    (stop),
        .scl_rise(scl_rise),
        .scl_fall(scl_fall)
    );

    // strap capture on the first clock after reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= 1'b0;
            cap_q <= 1'b1;
        end else if (cap_q) begin
            sel_q <= addr_sel;
            cap_q <= 1'b0;
        end
    end

    assign dev_code  = sel_q ? DEV_CODE_HI : DEV_CODE_LO;
    assign byte_full = (bitcnt == CNT_W'(DATA_W));
    assign addr_hit  = (shreg[DATA_W-1:1] == dev_code);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (start) begin
            state_d = ST_DEV;
        end else if (stop) begin
            state_d = ST_IDLE;
        end else if (scl_fall) begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_IDLE;
                ST_DEV:      if (byte_full) state_d = addr_hit ? ST_DEV_ACK : ST_IDLE;
                ST_DEV_ACK:  state_d = rw_q ? ST_TX : ST_PTR;
                ST_PTR:      if (byte_full) state_d = ST_PTR_ACK;
                ST_PTR_ACK:  state_d = ST_WDAT;
                ST_WDAT:     if (byte_full) state_d = ST_WDAT_ACK;
                ST_WDAT_ACK: state_d = ST_IDLE;
                ST_TX:       if (byte_full) state_d = ST_TX_ACK;
                ST_TX_ACK:   state_d = ST_IDLE;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt <= '0;
            shreg  <= '0;
            ptr_q  <= '0;
            rw_q   <= 1'b0;
            sda_oe <= 1'b0;
            reg_we <= 1'b0;
        end else begin
            reg_we <= 1'b0;
            if (start || stop) begin
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_DEV, ST_PTR, ST_WDAT: begin
                        if (scl_rise && !byte_full) begin
                            shreg  <= {shreg[DATA_W-2:0], sda_s};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (scl_fall && byte_full) begin
                            bitcnt <= '0;
                            sda_oe <= (state_q != ST_DEV) || addr_hit;
                            if (state_q == ST_DEV) rw_q  <= shreg[0];
                            if (state_q == ST_PTR) ptr_q <= shreg;
                        end
                    end
                    ST_DEV_ACK: begin
                        if (scl_fall) begin
                            if (rw_q) begin
                                shreg  <= reg_rdata;
                                sda_oe <= ~reg_rdata[DATA_W-1];
                            end else begin
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    ST_PTR_ACK: if (scl_fall) sda_oe <= 1'b0;
                    ST_WDAT_ACK: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            reg_we <= 1'b1;
                        end
                    end
                    ST_TX: begin
                        if (scl_rise) begin
                            bitcnt <= bitcnt + 1'b1;
                        end else if (scl_fall) begin
                            if (byte_full) begin
                                bitcnt <= '0;
                                sda_oe <= 1'b0;
                            end else begin
                                shreg  <= {shreg[DATA_W-2:0], 1'b0};
                                sda_oe <= ~shreg[DATA_W-2];
                            end
                        end
                    end
                    ST_IDLE, ST_TX_ACK: sda_oe <= 1'b0;
                    default: sda_oe <= 1'b0;
                endcase
            end
        end
    end

    assign reg_addr  = ptr_q;
    assign reg_wdata = shreg;

endmodule

module twi_reg_slave_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_i,
    input logic              sda_oe,
    input logic              reg_we,
    input logic [DATA_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata
);

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!sda_oe && !reg_we));

    assert_oe_rise_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_i);

    assert_we_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    assert_we_after_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> ($past(sda_oe) && !sda_oe));

    assert_we_fields_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> ($stable(reg_addr) && $stable(reg_wdata)));

endmodule

bind twi_reg_slave twi_reg_slave_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_oe   (sda_oe),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata)
);

// File: tb/sim_twi_reg_slave.sv
module sim_twi_reg_slave;

    localparam int H = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr_sel = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_oe, reg_we;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    logic       sda_bus;
    logic [7:0] mem [256];
    logic [7:0] mdl [256];
    logic [15:0] exp_wq[$];
    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    always #4 clk = ~clk;

    assign sda_bus   = sda_m & ~sda_oe;
    assign reg_rdata = mem[reg_addr];

    twi_reg_slave u0 (
        .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel),
        .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
        .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) if (reg_we) mem[reg_addr] <= reg_wdata;

    // per-clock comparison of write strobes against the expected queue
    always @(negedge clk) begin
        if (rst_n && reg_we) begin
            if (exp_wq.size() == 0) chk("R6", 1, 0, "unexpected write");
            else chk("R6", {reg_addr, reg_wdata}, exp_wq.pop_front(), "write addr/data");
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic clk_bit(input logic b, output logic seen);
        tick(H/2); sda_m = b;
        tick(H/2); scl_m = 1'b1;
        tick(H/2); seen = sda_bus;
        tick(H/2); scl_m = 1'b0;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(H/2);
        scl_m = 1'b1; tick(H/2);
        sda_m = 1'b0; tick(H/2);
        scl_m = 1'b0; tick(H/2);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(H/2);
        scl_m = 1'b1; tick(H/2);
        sda_m = 1'b1; tick(H);
        chk("R2", sda_oe, 0, "released after stop");
    endtask

    task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
        logic s;
        bit   loud = 0;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(b[i], s);
            if (s !== b[i]) loud = 1;
        end
        chk("R5", loud, 0, "slave quiet while receiving");
        clk_bit(1'b1, s);
        chk(req, !s, exp_ack, "acknowledge");
    endtask

    task automatic recv_byte(output logic [7:0] v, input bit mack);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            v[i] = s;
        end
        clk_bit(mack ? 1'b0 : 1'b1, s);
    endtask

    task automatic do_write(input logic [6:0] dev, input logic [7:0] a, input logic [7:0] d);
        bus_start();
        send_byte({dev, 1'b0}, 1, "R3");
        send_byte(a, 1, "R5");
        exp_wq.push_back({a, d});
        mdl[a] = d;
        send_byte(d, 1, "R6");
    endtask

    task automatic do_read(input logic [6:0] dev, input logic [7:0] a, output logic [7:0] v);
        bus_start();
        send_byte({dev, 1'b0}, 1, "R3");
        send_byte(a, 1, "R5");
        bus_start();
        send_byte({dev, 1'b1}, 1, "R8");
        recv_byte(v, 0);
        bus_stop();
    endtask

    initial begin
        logic [7:0] v;
        logic       s;
        for (int i = 0; i < 256; i++) begin
            mem[i] = 8'(i * 7 + 3);
            mdl[i] = 8'(i * 7 + 3);
        end
        tick(5);
        rst_n = 1'b1;
        tick(3);
        chk("R1", sda_oe, 0, "sda_oe after reset");
        chk("R1", reg_we, 0, "reg_we after reset");

        // plain write then read back
        do_write(7'h55, 8'h12, 8'hA5);
        bus_stop();
        do_read(7'h55, 8'h12, v);
        chk("R8", v, mdl[8'h12], "read data");

        // reads with MSB 0 / MSB 1 and all-ones, all-zeros patterns
        do_write(7'h55, 8'h80, 8'h00); bus_stop();
        do_write(7'h55, 8'h81, 8'hFF); bus_stop();
        do_write(7'h55, 8'h82, 8'h6B); bus_stop();
        do_read(7'h55, 8'h80, v); chk("R8", v, 8'h00, "read zeros");
        do_read(7'h55, 8'h81, v); chk("R8", v, 8'hFF, "read ones");
        do_read(7'h55, 8'h82, v); chk("R8", v, 8'h6B, "read mixed");
        do_read(7'h55, 8'h40, v); chk("R8", v, mdl[8'h40], "read preset");

        // master acknowledges: slave must not drive a second byte
        bus_start();
        send_byte({7'h55, 1'b0}, 1, "R3");
        send_byte(8'h12, 1, "R5");
        bus_start();
        send_byte({7'h55, 1'b1}, 1, "R8");
        recv_byte(v, 1);
        chk("R8", v, mdl[8'h12], "read before master ack");
        recv_byte(v, 0);
        chk("R9", v, 8'hFF, "line released after read byte");
        bus_stop();

        // write ended by repeated start, then another write
        do_write(7'h55, 8'h30, 8'h5A);
        do_write(7'h55, 8'h31, 8'hC3);
        bus_stop();

        // extra byte after a completed write
        do_write(7'h55, 8'h32, 8'h11);
        send_byte(8'h77, 0, "R7");
        bus_stop();
        chk("R7", mem[8'h32], 8'h11, "no second write");

        // address mismatch: nothing acknowledged, nothing written
        bus_start();
        send_byte({7'h33, 1'b0}, 0, "R4");
        send_byte(8'h12, 0, "R4");
        send_byte(8'hEE, 0, "R4");
        bus_stop();
        chk("R4", mem[8'h12], mdl[8'h12], "no write on mismatch");

        // start in the middle of a byte
        bus_start();
        for (int i = 0; i < 3; i++) clk_bit(1'b1, s);
        do_write(7'h55, 8'h20, 8'h3C);
        bus_stop();

        // stop in the middle of a byte
        bus_start();
        send_byte({7'h55, 1'b0}, 1, "R3");
        for (int i = 0; i < 4; i++) clk_bit(1'b0, s);
        bus_stop();
        do_write(7'h55, 8'h21, 8'h96);
        bus_stop();
        do_read(7'h55, 8'h21, v);
        chk("R2", v, 8'h96, "clean transfer after mid-byte stop");

        // strap moved without reset: still the low code
        addr_sel = 1'b1;
        tick(4);
        bus_start();
        send_byte({7'h33, 1'b0}, 0, "R3");
        bus_stop();
        do_write(7'h55, 8'h22, 8'h44);
        bus_stop();

        // reset with strap high: high code only
        rst_n = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(3);
        chk("R1", sda_oe, 0, "sda_oe after second reset");
        bus_start();
        send_byte({7'h55, 1'b0}, 0, "R3");
        bus_stop();
        do_write(7'h33, 8'h23, 8'hB7);
        bus_stop();
        do_read(7'h33, 8'h23, v);
        chk("R3", v, 8'hB7, "read with high code");

        tick(4);
        chk("R6", exp_wq.size(), 0, "pending expected writes");
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            nchk++;
            nerr++;
            $display("FAIL watchdog: act=hung exp=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

endmodule